// File: doc/BRIEF.md
# Event Readout Buffer with Host Handshake

This block sits between an event formatter and a 32-bit host bus slave port. Payload words come in on a valid/ready stream. The block wraps each event in a fixed frame and writes the frame into an event window that holds `BUF_WORDS` words. The frame is a DAQ header, an optional subsystem header, the payload and a DAQ trailer. When an event, or a window-sized piece of a longer event, is complete, the block raises a ready flag and stops taking new words. The host polls that flag, reads the chunk length and drains the window with single or block reads. It then writes to the status register to release the block for the next chunk or event.

The board answers a 64 KB window whose base comes from a 6-bit slot number. The window is divided into eight 8 KB regions, selected by address bits 15:13. Region 0 holds the control registers and region 4 holds the event window. Every other region reads as zero.

Upstream stream rules: a word moves on a rising clock edge when `in_valid` and `in_ready` are both high. The formatter must hold `in_data`, `in_last` and `sub_hdr_en` stable while `in_valid` is high and the word has not been accepted. `in_ready` is high only while payload is being taken and the ready flag is clear. `in_ready` stays low during the cycles in which the block writes header words, and the formatter must simply wait through them.

Top module: `event_readout_buffer`

## Requirements
- R1: The block responds to a request only when `bus_addr[31:22]` is zero and `bus_addr[21:16]` equals `slot_id`. Any other request produces neither `bus_ack` nor `bus_err`.
- R2: A decoded request gets exactly one response in the cycle after it: either `bus_ack`, with `bus_rdata` for reads, or `bus_err`. The response is `bus_err` when `bus_acc32` is low or `bus_addr[1:0]` is nonzero.
- R3: A block transfer (`bus_blk` high) into region 0 (offsets 0x0000–0x1FFF) gets `bus_err`. Block reads from region 4 are acknowledged.
- R4: Each event is stored in this order. First a header word `{8'h5F, event number[23:0]}`, with event numbers counting from 0 after reset. Next, if `sub_hdr_en` is high with the first word of the event, the subsystem word `32'h3C00_0000`; otherwise nothing. Then the payload words in arrival order. Last, a trailer word `{8'hA0, total word count[23:0]}`, where the count includes the headers and the trailer. Word i of the window reads at offset 0x8000 + 4*i.
- R5: The status register at offset 0x0004 reads bit 0 = ready and bit 1 = more chunks follow. The length register at offset 0x0008 reads the number of valid words in the presented chunk.
- R6: A write with nonzero data to offset 0x0004 while the ready flag is set clears both status bits and lets the block continue. A write with zero data has no effect on the flag.
- R7: The `busy` output equals the ready flag. While `busy` is high, `in_ready` is low.
- R8: When the window fills before the trailer is written, the chunk is presented with bit 1 set and a length of `BUF_WORDS`. The chunk that holds the trailer is presented with bit 1 clear. An event of exactly `BUF_WORDS` words is one final chunk.
- R9: Offset 0x0000 reads `ID_WORD`, and writes to it are ignored.
- R10: Reads from regions other than 0 and 4, from unused offsets in region 0, and from window offsets at or beyond `BUF_WORDS` return zero with `bus_ack`. Host writes into the event window do not change its contents.
- R11: After reset, status reads 0, length reads 0, and `busy` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_id | input | 6 | Slot number, compared with address bits 21:16 |
| bus_req | input | 1 | One-cycle host access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_blk | input | 1 | Access is part of a block transfer |
| bus_acc32 | input | 1 | Access is a full 32-bit transfer |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completed, one cycle after the request |
| bus_err | output | 1 | Access refused, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| in_valid | input | 1 | Formatter word valid |
| in_ready | output | 1 | Block accepts the word |
| in_data | input | 32 | Payload word |
| in_last | input | 1 | Last payload word of the event |
| sub_hdr_en | input | 1 | Event carries a subsystem header word |
| busy | output | 1 | Throttle toward the formatter: a chunk awaits the host |

## Verification
The framing path is driven with six events of different shapes: short events with and without the subsystem word, an event one word longer than the window, an event that fills the window exactly, an event of two full windows, and a single-payload event. Together these separate the "more" bit from the final-chunk case, confirm the trailer count spans chunks, and check that event numbering runs across events. The host side is probed with foreign slots, foreign upper address bits, sub-word and misaligned accesses, block access to the control region, reserved-region reads, and writes to the ID, window and status registers. These show which accesses are silent, which are refused and which are ignored. Zero-data status writes made while a chunk waits distinguish a real clear from a stray write.

// File: rtl/erb_pkg.sv
package erb_pkg;
  typedef enum logic [1:0] {WS_IDLE, WS_SUB, WS_PAY, WS_TRL} wr_state_t;

  localparam logic [2:0]  REGION_CSR = 3'd0;
  localparam logic [2:0]  REGION_BUF = 3'd4;
  localparam logic [10:0] OFF_ID     = 11'd0;
  localparam logic [10:0] OFF_STAT   = 11'd1;
  localparam logic [10:0] OFF_LEN    = 11'd2;

  localparam logic [7:0]  HDR_TAG    = 8'h5F;
  localparam logic [7:0]  TRL_TAG    = 8'hA0;
  localparam logic [31:0] SUB_WORD   = 32'h3C00_0000;
endpackage

// File: rtl/erb_decode.sv
module erb_decode (
  input  logic        bus_req,
  input  logic        bus_blk,
  input  logic        bus_acc32,
  input  logic [31:0] bus_addr,
  input  logic [5:0]  slot_id,
  output logic        hit,
  output logic        bad,
  output logic [2:0]  region,
  output logic [10:0] word_idx
);
  import erb_pkg::*;

  always_comb begin
    hit      = bus_req && (bus_addr[31:22] == 10'd0) && (bus_addr[21:16] == slot_id);
    region   = bus_addr[15:13];
    word_idx = bus_addr[12:2];
    bad      = !bus_acc32 || (bus_addr[1:0] != 2'b00) ||
               (bus_blk && (region == REGION_CSR));
  end
endmodule

// File: rtl/erb_buf_mem.sv
module erb_buf_mem #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/erb_frame_writer.sv
module erb_frame_writer #(
  parameter int BUF_WORDS = 2048,
  parameter int AW        = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  input  logic          in_last,
  input  logic          sub_en,
  output logic          in_ready,
  input  logic          host_clr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [31:0]   mem_wdata,
  output logic          rdy,
  output logic          more,
  output logic [AW:0]   chunk_len
);
  import erb_pkg::*;

  localparam logic [AW-1:0] LAST_SLOT = AW'(BUF_WORDS - 1);

  wr_state_t   st;
  logic [AW-1:0] wptr;
  logic [23:0] total;
  logic [23:0] evt;
  logic        win_full;

  assign mem_waddr = wptr;
  assign win_full  = (wptr == LAST_SLOT);

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = 32'd0;
    in_ready  = 1'b0;
    unique case (st)
      WS_IDLE: begin mem_we = in_valid && !rdy; mem_wdata = {HDR_TAG, evt}; end
      WS_SUB:  begin mem_we = !rdy;             mem_wdata = SUB_WORD; end
      WS_PAY:  begin mem_we = in_valid && !rdy; mem_wdata = in_data; in_ready = !rdy; end
      WS_TRL:  begin mem_we = !rdy;             mem_wdata = {TRL_TAG, total + 24'd1}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= WS_IDLE;
      wptr      <= '0;
      total     <= '0;
      evt       <= '0;
      rdy       <= 1'b0;
      more      <= 1'b0;
      chunk_len <= '0;
    end else begin
      if (host_clr && rdy) begin
        rdy  <= 1'b0;
        more <= 1'b0;
        wptr <= '0;
      end
      if (mem_we) begin
        wptr  <= wptr + 1'b1;
        total <= total + 24'd1;
        unique case (st)
          WS_IDLE: st <= sub_en ? WS_SUB : WS_PAY;
          WS_SUB:  st <= WS_PAY;
          WS_PAY:  if (in_last) st <= WS_TRL;
          WS_TRL:  st <= WS_IDLE;
          default: st <= WS_IDLE;
        endcase
        if (st == WS_TRL) begin
          rdy       <= 1'b1;
          more      <= 1'b0;
          chunk_len <= (AW+1)'(wptr) + 1'b1;
          evt       <= evt + 24'd1;
          total     <= '0;
        end else if (win_full) begin
          rdy       <= 1'b1;
          more      <= 1'b1;
          chunk_len <= (AW+1)'(BUF_WORDS);
        end
      end
    end
  end
endmodule

// File: rtl/event_readout_buffer.sv
module event_readout_buffer #(
  parameter int          BUF_WORDS = 2048,
  parameter logic [31:0] ID_WORD   = 32'h0EB0_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  slot_id,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic        bus_blk,
  input  logic        bus_acc32,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        bus_ack,
  output logic        bus_err,
  output logic [31:0] bus_rdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_last,
  input  logic        sub_hdr_en,
  output logic        busy
);
  import erb_pkg::*;

  localparam int AW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  logic          hit, bad;
  logic [2:0]    region;
  logic [10:0]   word_idx;
  logic          host_clr;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          rdy, more;
  logic [AW:0]   chunk_len;
  logic [31:0]   csr_val, csr_q;
  logic          sel_buf, sel_buf_q;

  erb_decode u_dec (
    .bus_req(bus_req), .bus_blk(bus_blk), .bus_acc32(bus_acc32),
    .bus_addr(bus_addr), .slot_id(slot_id),
    .hit(hit), .bad(bad), .region(region), .word_idx(word_idx)
  );

  erb_frame_writer #(.BUF_WORDS(BUF_WORDS), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .sub_en(sub_hdr_en), .in_ready(in_ready), .host_clr(host_clr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rdy(rdy), .more(more), .chunk_len(chunk_len)
  );

  erb_buf_mem #(.DEPTH(BUF_WORDS), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(word_idx[AW-1:0]), .rdata(mem_rdata)
  );

  assign host_clr = hit && !bad && bus_we && (region == REGION_CSR) &&
                    (word_idx == OFF_STAT) && (bus_wdata != 32'd0);
  assign sel_buf  = !bus_we && (region == REGION_BUF) &&
                    ({21'd0, word_idx} < BUF_WORDS);
  assign busy     = rdy;

  always_comb begin
    csr_val = 32'd0;
    if (!bus_we && region == REGION_CSR) begin
      unique case (word_idx)
        OFF_ID:   csr_val = ID_WORD;
        OFF_STAT: csr_val = {30'd0, more, rdy};
        OFF_LEN:  csr_val = 32'(chunk_len);
        default:  csr_val = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      csr_q     <= '0;
      sel_buf_q <= 1'b0;
    end else begin
      bus_ack   <= hit && !bad;
      bus_err   <= hit && bad;
      csr_q     <= csr_val;
      sel_buf_q <= sel_buf;
    end
  end

  assign bus_rdata = !bus_ack ? 32'd0 : (sel_buf_q ? mem_rdata : csr_q);
endmodule

// File: rtl/erb_checker.sv
module erb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  slot_id,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_blk,
  input logic [31:0] bus_addr,
  input logic        bus_ack,
  input logic        bus_err,
  input logic        in_ready,
  input logic        busy
);
  logic ours;
  assign ours = bus_req && (bus_addr[31:22] == 10'd0) && (bus_addr[21:16] == slot_id);

  p_foreign_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !ours) |=> (!bus_ack && !bus_err));

  p_resp_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack || bus_err) |-> $past(bus_req));

  p_ack_err_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_err));

  p_blk_csr_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ours && bus_blk && bus_addr[15:13] == 3'd0) |=> bus_err);

  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(bus_req && bus_we)) |=> busy);

  p_busy_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

bind event_readout_buffer erb_checker u_chk (.*);

// File: tb/event_readout_buffer_tb.sv
module event_readout_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUFW = 8;
  localparam logic [31:0] IDW  = 32'h0EB0_0001;
  localparam logic [31:0] BASE = 32'h0011_0000;

  logic clk = 0, rst_n = 0;
  logic [5:0] slot_id = 6'd17;
  logic bus_req = 0, bus_we = 0, bus_blk = 0, bus_acc32 = 1;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic in_valid = 0, in_last = 0, sub_hdr_en = 0;
  logic [31:0] in_data = 0;
  logic in_ready, busy;

  int vectors = 0, errors = 0;
  logic [31:0] exp_q[$];
  int len_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  event_readout_buffer #(.BUF_WORDS(BUFW), .ID_WORD(IDW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(!(busy && in_ready), "R7 in_ready while busy", {31'd0, in_ready}, 32'd0);
    chk(!(bus_ack && bus_err), "R2 ack with err", {31'd0, bus_err}, 32'd0);
  end

  task automatic bus_op(input logic we, blk, acc, input logic [31:0] a, wd,
                        output logic ack, err, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_blk = blk; bus_acc32 = acc;
    bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_req = 0; bus_we = 0; bus_blk = 0; bus_acc32 = 1;
    ack = bus_ack; err = bus_err; rd = bus_rdata;
  endtask

  task automatic rd_ok(input logic blk, input logic [31:0] a, exp, input string req);
    logic ack, err; logic [31:0] rd;
    bus_op(0, blk, 1, a, 0, ack, err, rd);
    chk(ack && !err && rd == exp, req, rd, exp);
  endtask

  task automatic produce(input int k, input int n, input bit sub);
    int tot = 2 + n + int'(sub);
    exp_q.push_back({8'h5F, 24'(k)});
    if (sub) exp_q.push_back(32'h3C00_0000);
    for (int i = 0; i < n; i++) exp_q.push_back({8'(k), 24'(i*3+1)});
    exp_q.push_back({8'hA0, 24'(tot)});
    len_q.push_back(tot);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = {8'(k), 24'(i*3+1)}; in_last = (i == n-1); sub_hdr_en = sub;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic consume(input bit first);
    int rem, chunk, polls;
    logic ack, err; logic [31:0] rd;
    while (len_q.size() == 0) @(negedge clk);
    rem = len_q.pop_front();
    while (rem > 0) begin
      chunk = (rem > BUFW) ? BUFW : rem;
      polls = 0;
      do begin
        bus_op(0, 0, 1, BASE + 32'h4, 0, ack, err, rd);
        polls++;
      end while (!rd[0] && polls < 500);
      chk(rd[1:0] == {rem > chunk, 1'b1}, "R5 R8 status bits", rd, {30'd0, rem > chunk, 1'b1});
      chk(busy == 1'b1, "R7 busy while ready", {31'd0, busy}, 32'd1);
      rd_ok(0, BASE + 32'h8, chunk, "R5 R8 chunk length");
      if (first) begin
        bus_op(1, 0, 1, BASE + 32'h4, 32'd0, ack, err, rd);
        rd_ok(0, BASE + 32'h4, {30'd0, rem > chunk, 1'b1}, "R6 zero write keeps status");
        bus_op(1, 1, 1, BASE + 32'h8000, 32'hDEAD_BEEF, ack, err, rd);
        chk(ack && !err, "R10 window write acked", {30'd0, err, ack}, 32'd1);
        rd_ok(1, BASE + 32'h8000 + BUFW*4, 32'd0, "R10 read beyond window");
        first = 0;
      end
      for (int i = 0; i < chunk; i++) begin
        logic [31:0] e = exp_q.pop_front();
        rd_ok(1, BASE + 32'h8000 + 32'(i*4), e, "R4 R8 R10 window word");
      end
      rem -= chunk;
      bus_op(1, 0, 1, BASE + 32'h4, 32'd1, ack, err, rd);
      chk(ack && !err, "R6 clear acked", {30'd0, err, ack}, 32'd1);
    end
  endtask

  task automatic directed();
    logic ack, err; logic [31:0] rd;
    chk(!busy && !in_ready, "R11 reset outputs", {30'd0, busy, in_ready}, 32'd0);
    rd_ok(0, BASE + 32'h4, 32'd0, "R11 reset status");
    rd_ok(0, BASE + 32'h8, 32'd0, "R11 reset length");
    rd_ok(0, BASE, IDW, "R9 id read");
    bus_op(1, 0, 1, BASE, 32'h1234_5678, ack, err, rd);
    rd_ok(0, BASE, IDW, "R9 id write ignored");
    bus_op(0, 0, 1, 32'h0012_0004, 0, ack, err, rd);
    chk(!ack && !err, "R1 other slot silent", {30'd0, err, ack}, 32'd0);
    bus_op(0, 0, 1, 32'h4011_0004, 0, ack, err, rd);
    chk(!ack && !err, "R1 upper bits silent", {30'd0, err, ack}, 32'd0);
    bus_op(0, 0, 0, BASE + 32'h4, 0, ack, err, rd);
    chk(!ack && err, "R2 sub-word refused", {30'd0, err, ack}, 32'd2);
    bus_op(0, 0, 1, BASE + 32'h5, 0, ack, err, rd);
    chk(!ack && err, "R2 misaligned refused", {30'd0, err, ack}, 32'd2);
    bus_op(0, 1, 1, BASE + 32'h4, 0, ack, err, rd);
    chk(!ack && err, "R3 block into control refused", {30'd0, err, ack}, 32'd2);
    rd_ok(0, BASE + 32'hA000, 32'd0, "R10 reserved reads zero");
    rd_ok(0, BASE + 32'h2004, 32'd0, "R10 region 1 reads zero");
    rd_ok(0, BASE + 32'h40, 32'd0, "R10 unused control offset");
    bus_op(1, 0, 1, BASE + 32'h4, 32'd1, ack, err, rd);
    chk(!busy, "R6 clear when idle ignored", {31'd0, busy}, 32'd0);
    rd_ok(0, BASE + 32'h4, 32'd0, "R6 status still clear");
  endtask

  initial begin
    bit done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    fork
      begin
        directed();
        fork
          begin
            produce(0, 3, 0);  produce(1, 4, 1); produce(2, 6, 1);
            produce(3, 5, 1);  produce(4, 14, 0); produce(5, 1, 0);
          end
          begin
            for (int k = 0; k < 6; k++) consume(k == 0);
          end
        join
        rd_ok(0, BASE + 32'h4, 32'd0, "R6 status clear at end");
        done = 1;
      end
      begin
        repeat (100000) @(posedge clk);
      end
    join_any
    disable fork;
    if (!done) chk(0, "watchdog", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule